// File: doc/BRIEF.md
# General-Purpose Timer with Compare Channels

A register-mapped timer with a counter, for use as a system time base and an event source. The counter advances once for every prescaled tick of a selected clock enable. Software selects one of four tick sources. A prescaler divides the selected source by N+1. A global enable gates counting. Three run bits decide whether the counter keeps going while the chip is in stop, wait or debug mode.

Two compare channels watch the counter, and a rollover detector watches for the wrap. Each of these raises a sticky status flag. Software clears a flag by writing a 1 to its bit. The interrupt output is the OR of the flags whose enable bits are set. In restart mode a match on compare channel 1 returns the counter to zero on the following tick, which gives a periodic event. In free-run mode the counter ignores matches and wraps at its full width. A software reset bit returns the whole block to its reset state in one write.

The register bus is single-cycle. A write takes effect at the clock edge on which `req_i` and `we_i` are high. Read data is combinational from `addr_i`. The register map uses word index `addr_i`: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 compare 1, 5 compare 2, 6 counter (read-only), 7 reads zero.

Top module: `gp_timer`

## Requirements
- R1: After reset every register, including the counter, reads 0 at all eight addresses, and `irq_o` is low.
- R2: The counter changes only on a prescaled tick. A tick needs control bit 0 (enable) set, and the counter then rises by exactly 1. With bit 0 clear the counter holds.
- R3: With prescaler value N, the counter advances once per N+1 pulses of the selected source. If N is lowered below the prescaler's current phase, the next source pulse produces a tick.
- R4: Control bits [7:5] select the tick source. Value 1 selects `per_tick_i`, 2 `fast_tick_i`, 3 `slow_tick_i` and 4 `ext_tick_i`. Values 0, 5, 6 and 7 select nothing, so the counter never advances. Pulses on unselected sources have no effect.
- R5: While `stop_i`, `wait_i` or `dbg_i` is high, the counter freezes unless control bit 2, 3 or 4 respectively is set.
- R6: Status bit 0 is set on the tick that brings the counter to the compare 1 value. Status bit 1 is set in the same way for compare 2.
- R7: Status bit 2 is set on the tick that wraps the counter from all-ones to zero.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing 0x7 clears all flags. Rewriting a compare register does not clear its flag.
- R9: When a flag's set event and a write-one-to-clear of that bit occur in the same cycle, the flag ends up set.
- R10: `irq_o` is high exactly when some status bit and the matching interrupt-enable bit (bits [2:0]) are both set.
- R11: With control bit 1 clear (restart mode), the tick after the counter equals compare 1 loads zero. With bit 1 set (free-run), the counter keeps incrementing past matches.
- R12: Writing control with bit 15 set clears every register, the counter and the prescaler phase. The other bits of that same write are discarded, and bit 15 reads back 0.
- R13: The counter reads at address 6, and writes to address 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| per_tick_i | input | 1 | Peripheral clock enable (source 1) |
| fast_tick_i | input | 1 | Double-rate clock enable (source 2) |
| slow_tick_i | input | 1 | 32 kHz clock enable (source 3) |
| ext_tick_i | input | 1 | External clock enable, already synchronized (source 4) |
| stop_i | input | 1 | Chip in stop mode |
| wait_i | input | 1 | Chip in wait mode |
| dbg_i | input | 1 | Chip in debug mode |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, and each has a distinct failure signature:
- A set event that collides with a clear in the same cycle. A design that lets the clear win loses the event, and the status bit reads 0.
- Lowering the prescaler below the current phase. A prescaler that tests equality instead of greater-or-equal runs through its whole range before it ticks again.
- The restart reload. If it happens a tick early or late, the counter reads 26 or 1 where 0 is expected.
- Counting through a full wrap on a narrowed counter. A design that mistakes the restart reload for a wrap, or that misses the wrap, reports the wrong status pattern.
- A software reset write that also carries configuration bits. A design that keeps those bits leaves the counter running afterwards.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int NUM_CMP  = 2;
  localparam int STAT_W   = NUM_CMP + 1;
  localparam int ROV_BIT  = NUM_CMP;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int NUM_MODE = 3;
  localparam int NUM_SRC  = 4;
  localparam int SRST_BIT = 15;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_PRESC = 3'd1,
    A_STAT  = 3'd2,
    A_IEN   = 3'd3,
    A_CMP1  = 3'd4,
    A_CMP2  = 3'd5,
    A_CNT   = 3'd6
  } reg_addr_e;

  // bit 0 en, bit 1 free_run, bits 4:2 mode run (stop, wait, dbg), bits 7:5 source
  typedef struct packed {
    logic [2:0]          src;
    logic [NUM_MODE-1:0] mode_run;
    logic                free_run;
    logic                en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale
  import gpt_pkg::*;
#(
  parameter int PRESC_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_clr_i,
  input  logic                en_i,
  input  logic [2:0]          src_i,
  input  logic [NUM_SRC-1:0]  src_tick_i,
  input  logic [NUM_MODE-1:0] mode_i,
  input  logic [NUM_MODE-1:0] mode_run_i,
  input  logic [PRESC_W-1:0]  presc_i,
  output logic                tick_o
);
  logic [NUM_MODE-1:0] mode_ok;
  logic                src_pulse;
  logic                run;
  logic [PRESC_W-1:0]  phase_q;

  for (genvar m = 0; m < NUM_MODE; m++) begin : g_mode
    assign mode_ok[m] = !mode_i[m] || mode_run_i[m];
  end

  always_comb begin
    src_pulse = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_i == 3'(s + 1)) src_pulse = src_tick_i[s];
    end
  end

  assign run    = en_i && (&mode_ok) && src_pulse;
  // >= so that lowering the divider below the current phase ticks at once
  assign tick_o = run && (phase_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (soft_clr_i) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= tick_o ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           soft_clr_i,
  input  logic                           tick_i,
  input  logic                           free_run_i,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_i,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [STAT_W-1:0]              set_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             restart;
  logic             wrap;

  assign restart = !free_run_i && (cnt_q == cmp_i[0]);
  assign wrap    = !restart && (&cnt_q);
  assign cnt_nxt = restart ? '0 : cnt_q + 1'b1;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    assign set_o[c] = tick_i && (cnt_nxt == cmp_i[c]);
  end
  assign set_o[ROV_BIT] = tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (soft_clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [STAT_W-1:0]             set_i,
  output ctrl_t                         ctrl_o,
  output logic [PRESC_W-1:0]            presc_o,
  output logic [NUM_CMP-1:0][CNT_W-1:0] cmp_o,
  output logic [STAT_W-1:0]             stat_o,
  output logic [STAT_W-1:0]             ien_o,
  output logic                          soft_clr_o
);
  logic                          wr;
  ctrl_t                         ctrl_q;
  logic [PRESC_W-1:0]            presc_q;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [STAT_W-1:0]             stat_q;
  logic [STAT_W-1:0]             ien_q;
  logic [STAT_W-1:0]             clr;

  assign wr         = req_i && we_i;
  assign soft_clr_o = wr && (addr_i == A_CTRL) && wdata_i[SRST_BIT];
  assign clr        = (wr && addr_i == A_STAT) ? wdata_i[STAT_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
    end else if (soft_clr_o) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
    end else begin
      // set beats clear
      stat_q <= (stat_q & ~clr) | set_i;
      if (wr && addr_i == A_CTRL)  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr && addr_i == A_PRESC) presc_q <= wdata_i[PRESC_W-1:0];
      if (wr && addr_i == A_IEN)   ien_q   <= wdata_i[STAT_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp_reg
    localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(int'(A_CMP1) + c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        cmp_q[c] <= '0;
      else if (soft_clr_o)                cmp_q[c] <= '0;
      else if (wr && addr_i == CMP_ADDR)  cmp_q[c] <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = DATA_W'(ctrl_q);
      A_PRESC: rdata_o = DATA_W'(presc_q);
      A_STAT:  rdata_o = DATA_W'(stat_q);
      A_IEN:   rdata_o = DATA_W'(ien_q);
      A_CNT:   rdata_o = DATA_W'(cnt_i);
      default: begin
        for (int c = 0; c < NUM_CMP; c++) begin
          if (addr_i == ADDR_W'(int'(A_CMP1) + c)) rdata_o = DATA_W'(cmp_q[c]);
        end
      end
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign presc_o = presc_q;
  assign cmp_o   = cmp_q;
  assign stat_o  = stat_q;
  assign ien_o   = ien_q;
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              per_tick_i,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              ext_tick_i,
  input  logic              stop_i,
  input  logic              wait_i,
  input  logic              dbg_i,
  output logic              irq_o
);
  ctrl_t                         ctrl;
  logic [PRESC_W-1:0]            presc;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp;
  logic [STAT_W-1:0]             stat;
  logic [STAT_W-1:0]             stat_set;
  logic [STAT_W-1:0]             ien;
  logic [CNT_W-1:0]              cnt;
  logic                          soft_clr;
  logic                          tick;

  gpt_regs #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cnt_i      (cnt),
    .set_i      (stat_set),
    .ctrl_o     (ctrl),
    .presc_o    (presc),
    .cmp_o      (cmp),
    .stat_o     (stat),
    .ien_o      (ien),
    .soft_clr_o (soft_clr)
  );

  gpt_prescale #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_clr),
    .en_i       (ctrl.en),
    .src_i      (ctrl.src),
    .src_tick_i ({ext_tick_i, slow_tick_i, fast_tick_i, per_tick_i}),
    .mode_i     ({dbg_i, wait_i, stop_i}),
    .mode_run_i (ctrl.mode_run),
    .presc_i    (presc),
    .tick_o     (tick)
  );

  gpt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_clr),
    .tick_i     (tick),
    .free_run_i (ctrl.free_run),
    .cmp_i      (cmp),
    .cnt_o      (cnt),
    .set_o      (stat_set)
  );

  assign irq_o = |(stat & ien);
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic              tick,
  input logic              soft_clr,
  input logic              en,
  input logic              free_run,
  input logic [2:0]        src,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp_first,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] stat_set
);
  logic wr_stat;
  logic wr_ien_zero;
  logic src_none;

  assign wr_stat     = req_i && we_i && (addr_i == A_STAT);
  assign wr_ien_zero = req_i && we_i && (addr_i == A_IEN) && (wdata_i[STAT_W-1:0] == '0);
  assign src_none    = (src == 3'd0) || (src > 3'd4);

  assert_hold_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !soft_clr) |=> $stable(cnt));

  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && free_run && !soft_clr) |=> (cnt == $past(cnt) + 1'b1));

  assert_disabled_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !tick);

  assert_no_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_none |-> !tick);

  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !free_run && cnt == cmp_first && !soft_clr) |=> (cnt == '0));

  assert_rollover_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (&cnt) && !soft_clr) |=> stat[ROV_BIT]);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stat && !soft_clr) |=> ((stat & $past(stat)) == $past(stat)));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|stat_set) && !soft_clr) |=> ((stat & $past(stat_set)) == $past(stat_set)));

  assert_irq_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ien_zero |=> !irq_o);

  assert_soft_reset_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr |=> (cnt == '0 && stat == '0 && !irq_o));
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .tick      (tick),
  .soft_clr  (soft_clr),
  .en        (ctrl.en),
  .free_run  (ctrl.free_run),
  .src       (ctrl.src),
  .cnt       (cnt),
  .cmp_first (cmp[0]),
  .stat      (stat),
  .stat_set  (stat_set)
);

// File: tb/gp_timer_tb_top.sv
module gp_timer_tb_top;
  localparam int CNT_W = 12;
  localparam logic [2:0] CTRL = 3'd0, PRESC = 3'd1, STAT = 3'd2, IEN = 3'd3,
                         CMP1 = 3'd4, CMP2 = 3'd5, CNT = 3'd6;
  localparam logic [3:0] S_PER = 4'b0001, S_FAST = 4'b0010, S_SLOW = 4'b0100,
                         S_EXT = 4'b1000, S_ALL = 4'b1111;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        per_tick_i = 1'b0, fast_tick_i = 1'b0, slow_tick_i = 1'b0, ext_tick_i = 1'b0;
  logic        stop_i = 1'b0, wait_i = 1'b0, dbg_i = 1'b0;
  logic        irq_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    kind_q[$];
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk_i = ~clk_i;

  gp_timer #(.CNT_W(CNT_W), .PRESC_W(12)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .per_tick_i(per_tick_i),
    .fast_tick_i(fast_tick_i), .slow_tick_i(slow_tick_i), .ext_tick_i(ext_tick_i),
    .stop_i(stop_i), .wait_i(wait_i), .dbg_i(dbg_i), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (kind_q.size() > 0) begin
        automatic int          k   = kind_q.pop_front();
        automatic logic [31:0] e   = exp_q.pop_front();
        automatic string       t   = tag_q.pop_front();
        automatic logic [31:0] act = (k == 0) ? rdata_o : {31'b0, irq_o};
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s: %s actual 0x%0h expected 0x%0h", t,
                   (k == 0) ? "read" : "irq", act, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic set_src(input logic [3:0] m);
    {ext_tick_i, slow_tick_i, fast_tick_i, per_tick_i} = m;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    @(negedge clk_i);
    set_src(m);
    repeat (n) @(negedge clk_i);
    set_src(4'b0);
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    set_src(m);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    set_src(4'b0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    addr_i = a;
    kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic irq_chk(input logic e, input string t);
    @(negedge clk_i);
    kind_q.push_back(1); exp_q.push_back({31'b0, e}); tag_q.push_back(t);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1");
    irq_chk(1'b0, "R1");

    // R2 enable gating (ctrl: en=1, free_run=2, src per = 1<<5)
    wr(PRESC, 0);
    wr(CTRL, 32'h23);
    pulse(S_PER, 5);
    rd(CNT, 5, "R2");
    wr(CTRL, 32'h22);
    pulse(S_PER, 3);
    rd(CNT, 5, "R2");

    // R4 source select
    wr(CTRL, 32'h63);            // slow
    pulse(S_PER | S_FAST | S_EXT, 4);
    rd(CNT, 5, "R4");
    pulse(S_SLOW, 2);
    rd(CNT, 7, "R4");
    wr(CTRL, 32'h03);            // none
    pulse(S_ALL, 3);
    rd(CNT, 7, "R4");
    wr(CTRL, 32'h43);            // fast
    pulse(S_FAST, 1);
    wr(CTRL, 32'h83);            // ext
    pulse(S_EXT, 1);
    rd(CNT, 9, "R4");
    wr(CTRL, 32'hC3);            // code 6 selects nothing
    pulse(S_ALL, 3);
    rd(CNT, 9, "R4");

    // R3 prescaler
    wr(PRESC, 2);
    wr(CTRL, 32'h23);
    pulse(S_PER, 3);
    rd(CNT, 10, "R3");
    pulse(S_PER, 5);
    rd(CNT, 11, "R3");
    wr(PRESC, 0);
    pulse(S_PER, 1);
    rd(CNT, 12, "R3");

    // R5 low-power and debug gating
    stop_i = 1'b1;
    pulse(S_PER, 2);
    rd(CNT, 12, "R5");
    wr(CTRL, 32'h27);
    pulse(S_PER, 2);
    rd(CNT, 14, "R5");
    stop_i = 1'b0; wait_i = 1'b1;
    pulse(S_PER, 1);
    rd(CNT, 14, "R5");
    wait_i = 1'b0; dbg_i = 1'b1;
    pulse(S_PER, 1);
    rd(CNT, 14, "R5");
    wr(CTRL, 32'h33);
    pulse(S_PER, 1);
    rd(CNT, 15, "R5");
    dbg_i = 1'b0;
    wr(CTRL, 32'h23);

    // R6 compare flags (free-run continues past matches: R11)
    wr(CMP1, 17);
    wr(CMP2, 19);
    pulse(S_PER, 2);
    rd(STAT, 1, "R6");
    pulse(S_PER, 2);
    rd(STAT, 3, "R6");
    rd(CNT, 19, "R11");

    // R8 write-one-to-clear
    wr(STAT, 2);
    rd(STAT, 1, "R8");
    wr(STAT, 0);
    rd(STAT, 1, "R8");
    wr(CMP1, 100);
    rd(STAT, 1, "R8");
    wr(STAT, 7);
    rd(STAT, 0, "R8");

    // R10 interrupt masking
    wr(CMP1, 20);
    pulse(S_PER, 1);
    irq_chk(1'b0, "R10");
    wr(IEN, 2);
    irq_chk(1'b0, "R10");
    wr(IEN, 1);
    irq_chk(1'b1, "R10");
    wr(STAT, 1);
    irq_chk(1'b0, "R10");
    wr(IEN, 0);

    // R9 set wins over simultaneous clear
    wr(CMP1, 22);
    pulse(S_PER, 1);
    wr_tick(STAT, 1, S_PER);
    rd(STAT, 1, "R9");
    rd(CNT, 22, "R9");
    wr(STAT, 7);

    // R11 restart mode
    wr(CMP1, 25);
    wr(CTRL, 32'h21);
    pulse(S_PER, 3);
    rd(CNT, 25, "R11");
    rd(STAT, 1, "R11");
    pulse(S_PER, 1);
    rd(CNT, 0, "R11");
    pulse(S_PER, 1);
    rd(CNT, 1, "R11");
    wr(STAT, 7);

    // R13 counter is read-only
    wr(CNT, 32'h55);
    rd(CNT, 1, "R13");

    // R7 rollover on full wrap
    wr(CTRL, 32'h23);
    wr(CMP1, 1);
    wr(CMP2, 1);
    pulse(S_PER, (1 << CNT_W) - 1);
    rd(CNT, 0, "R7");
    rd(STAT, 4, "R7");
    irq_chk(1'b0, "R10");
    wr(IEN, 4);
    irq_chk(1'b1, "R10");
    wr(STAT, 7);
    irq_chk(1'b0, "R8");

    // R12 software reset discards co-written bits
    pulse(S_PER, 3);
    rd(CNT, 3, "R12");
    wr(IEN, 7);
    wr(CMP1, 9);
    wr(PRESC, 5);
    wr(CTRL, 32'h8023);
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R12");
    irq_chk(1'b0, "R12");
    pulse(S_PER, 3);
    rd(CNT, 0, "R12");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule